// File: doc/BRIEF.md
# Subroutine Call Stack Sequencer

This block carries out the control-flow part of jump and call instructions for a small 8-bit processor. The processor's 16-bit program counter and a byte-wide stack grow toward lower addresses. The decoder presents the following on a one-cycle `start` pulse:

- the addressing mode,
- the operand bytes,
- the 8-bit index register,
- the address of the instruction's opcode,
- a flag that selects call rather than jump.

The sequencer latches these inputs and forms the target address. For a call, it also forms the return address and stores it on the stack one byte at a time through a plain byte-write port. It then loads its program counter output with the target.

The number of busy cycles depends only on the addressing mode and on whether the instruction is a call. A fetch unit can therefore rely on a fixed latency. A `done` pulse marks the final cycle, and the new program counter value appears on the clock edge that ends that cycle. The stack pointer is held inside the block. It starts at a parameter value and wraps around its width.

Top module: `call_seq`

## Requirements
- R1: After reset, `busy`, `done` and `mem_we` are 0, `pc_out` is 0 and `sp_out` equals the parameter `SP_INIT` (default 0xFF).
- R2: Mode codes are 0 = page-zero direct (target = opnd[7:0] zero-extended), 1 = extended (target = opnd), 2 = indexed with 16-bit offset (opnd + idx, modulo 2^16), 3 = indexed with 8-bit offset (opnd[7:0] + idx, with no truncation to 8 bits), 4 = indexed with no offset (target = idx).
- R3: A jump is accepted on a clock edge with `start` high and `busy` low. It keeps `busy` high for exactly 2 (direct), 3 (extended), 4 (16-bit offset), 3 (8-bit offset) or 2 (no offset) cycles, and `done` is high only in the last of these cycles.
- R4: A call takes exactly 5 (direct), 6 (extended), 7 (16-bit offset), 6 (8-bit offset) or 5 (no offset) busy cycles, and `done` is high only in the last of these cycles.
- R5: The return address of a call is the opcode address `pc_cur` plus the instruction length, modulo 2^16. The length is 1 for no offset, 2 for direct and 8-bit offset, and 3 for extended and 16-bit offset.
- R6: A call writes the return address low byte in busy cycle N-2 at `mem_addr` = current stack pointer. It writes the high byte in cycle N-1 at the stack pointer minus 1. The stack pointer drops by one after each write and wraps modulo 2^SP_W.
- R7: A jump asserts no `mem_we` and leaves `sp_out` unchanged.
- R8: A `start` request that arrives while `busy` is high is ignored. The running operation completes unchanged, and no extra operation follows.
- R9: A `start` with a mode code of 5, 6 or 7 is ignored. `busy` stays low, and `pc_out` and `sp_out` are unchanged.
- R10: `pc_out` takes the target address on the clock edge that ends the `done` cycle and holds its value at all other times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin a jump or call |
| is_call | input | 1 | 1 = call, 0 = jump |
| mode | input | 3 | Addressing mode code |
| opnd | input | 16 | Operand bytes; one-byte operands in [7:0] |
| idx | input | 8 | Index register value |
| pc_cur | input | 16 | Address of the instruction's opcode |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Final cycle of the operation |
| pc_out | output | 16 | Program counter |
| mem_we | output | 1 | Stack byte write strobe |
| mem_addr | output | SP_W | Stack write address (current stack pointer) |
| mem_wdata | output | 8 | Stack write data |
| sp_out | output | SP_W | Current stack pointer |

## Verification
The assertions check the following on every cycle:

- the busy countdown steps by one regardless of `start`;
- `done` is always followed by an idle cycle;
- a low-byte push is always followed by a high-byte push;
- the stack pointer moves only on a write;
- the program counter changes only at the end of `done`;
- an invalid mode never starts the block.

Only the bench scenarios can show that the target and return values are arithmetically right for each mode. They also show that the exact cycle counts per mode match, that the bytes land at the right addresses in the right order, and that the stack pointer wraps correctly.

// File: rtl/csq_pkg.sv
package csq_pkg;

    localparam int PC_W  = 16;
    localparam int D_W   = 8;
    localparam int CNT_W = 3;

    typedef enum logic [2:0] {
        AM_DIR = 3'd0,
        AM_EXT = 3'd1,
        AM_IX2 = 3'd2,
        AM_IX1 = 3'd3,
        AM_IX  = 3'd4
    } amode_e;

    typedef struct packed {
        logic            call;
        amode_e          mode;
        logic [PC_W-1:0] opnd;
        logic [D_W-1:0]  idx;
        logic [PC_W-1:0] pc;
    } req_t;

    function automatic logic mode_ok(logic [2:0] m);
        return m <= 3'd4;
    endfunction

    // bytes occupied by the instruction, opcode included
    function automatic logic [1:0] instr_len(amode_e m);
        case (m)
            AM_IX:          return 2'd1;
            AM_DIR, AM_IX1: return 2'd2;
            default:        return 2'd3;
        endcase
    endfunction

    // busy cycles; a call adds three (two pushes plus one)
    function automatic logic [CNT_W-1:0] op_cycles(amode_e m, logic call);
        logic [CNT_W-1:0] j;
        case (m)
            AM_DIR, AM_IX:  j = CNT_W'(2);
            AM_EXT, AM_IX1: j = CNT_W'(3);
            default:        j = CNT_W'(4);
        endcase
        return call ? j + CNT_W'(3) : j;
    endfunction

endpackage

// File: rtl/csq_addr.sv
module csq_addr
    import csq_pkg::*;
(
    input  req_t            req,
    output logic [PC_W-1:0] ea,
    output logic [PC_W-1:0] ret
);

    always_comb begin
        case (req.mode)
            AM_DIR:  ea = PC_W'(req.opnd[D_W-1:0]);
            AM_EXT:  ea = req.opnd;
            AM_IX2:  ea = req.opnd + PC_W'(req.idx);
            AM_IX1:  ea = PC_W'(req.opnd[D_W-1:0]) + PC_W'(req.idx);
            default: ea = PC_W'(req.idx);
        endcase
        ret = req.pc + PC_W'(instr_len(req.mode));
    end

endmodule

// File: rtl/csq_ctrl.sv
module csq_ctrl
    import csq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             valid,
    input  logic [CNT_W-1:0] n_cyc,
    input  logic             call_q,
    output logic             take,
    output logic             busy,
    output logic             done,
    output logic             push_lo,
    output logic             push_hi
);

    logic [CNT_W-1:0] cnt;

    assign busy    = (cnt != '0);
    assign done    = (cnt == CNT_W'(1));
    assign take    = start && valid && !busy;
    assign push_lo = call_q && (cnt == CNT_W'(3));
    assign push_hi = call_q && (cnt == CNT_W'(2));

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (take) cnt <= n_cyc;
        else if (busy) cnt <= cnt - CNT_W'(1);
    end

    // R8: a running countdown is never reloaded by start
    a_r8_count_steps: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> (busy && cnt == $past(cnt) - CNT_W'(1)));

    // R3 / R4: the done cycle is followed by an idle cycle
    a_r3_done_ends: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

    // R6: low byte is always followed by the high byte
    a_r6_push_pair: assert property (@(posedge clk) disable iff (rst)
        push_lo |=> (push_hi && !push_lo));

    // R9: an invalid request never starts the sequencer
    a_r9_bad_mode: assert property (@(posedge clk) disable iff (rst)
        (!busy && start && !valid) |=> !busy);

endmodule

// File: rtl/csq_stack.sv
module csq_stack
    import csq_pkg::*;
#(
    parameter int              SP_W    = 8,
    parameter logic [SP_W-1:0] SP_INIT = '1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            push_lo,
    input  logic            push_hi,
    input  logic [PC_W-1:0] ret,
    output logic            mem_we,
    output logic [SP_W-1:0] mem_addr,
    output logic [D_W-1:0]  mem_wdata,
    output logic [SP_W-1:0] sp
);

    logic [SP_W-1:0] sp_q;

    assign mem_we    = push_lo || push_hi;
    assign mem_addr  = sp_q;
    assign mem_wdata = push_hi ? ret[PC_W-1:PC_W-D_W] : ret[D_W-1:0];
    assign sp        = sp_q;

    always_ff @(posedge clk) begin
        if (rst)         sp_q <= SP_INIT;
        else if (mem_we) sp_q <= sp_q - 1'b1;
    end

    // R6: every write is followed by a single decrement (wrapping)
    a_r6_sp_dec: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> (sp_q == $past(sp_q) - 1'b1));

    // R7: without a write the pointer does not move
    a_r7_sp_hold: assert property (@(posedge clk) disable iff (rst)
        !mem_we |=> $stable(sp_q));

endmodule

// File: rtl/call_seq.sv
module call_seq
    import csq_pkg::*;
#(
    parameter int              SP_W    = 8,
    parameter logic [SP_W-1:0] SP_INIT = '1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic            is_call,
    input  logic [2:0]      mode,
    input  logic [15:0]     opnd,
    input  logic [7:0]      idx,
    input  logic [15:0]     pc_cur,
    output logic            busy,
    output logic            done,
    output logic [15:0]     pc_out,
    output logic            mem_we,
    output logic [SP_W-1:0] mem_addr,
    output logic [7:0]      mem_wdata,
    output logic [SP_W-1:0] sp_out
);

    req_t             req_in, req_q;
    logic             take, push_lo, push_hi;
    logic [PC_W-1:0]  ea, ret, pc_q;
    logic [CNT_W-1:0] n_cyc;

    always_comb begin
        req_in.call = is_call;
        req_in.mode = amode_e'(mode);
        req_in.opnd = opnd;
        req_in.idx  = idx;
        req_in.pc   = pc_cur;
        n_cyc       = op_cycles(req_in.mode, is_call);
    end

    always_ff @(posedge clk) begin
        if (rst)       req_q <= '0;
        else if (take) req_q <= req_in;
    end

    csq_addr u_addr (
        .req (req_q),
        .ea  (ea),
        .ret (ret)
    );

    csq_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .valid   (mode_ok(mode)),
        .n_cyc   (n_cyc),
        .call_q  (req_q.call),
        .take    (take),
        .busy    (busy),
        .done    (done),
        .push_lo (push_lo),
        .push_hi (push_hi)
    );

    csq_stack #(.SP_W(SP_W), .SP_INIT(SP_INIT)) u_stack (
        .clk       (clk),
        .rst       (rst),
        .push_lo   (push_lo),
        .push_hi   (push_hi),
        .ret       (ret),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .sp        (sp_out)
    );

    always_ff @(posedge clk) begin
        if (rst)       pc_q <= '0;
        else if (done) pc_q <= ea;
    end

    assign pc_out = pc_q;

    // R10: the program counter takes the target at the end of done
    a_r10_pc_load: assert property (@(posedge clk) disable iff (rst)
        done |=> (pc_q == $past(ea)));

    // R10: and holds otherwise
    a_r10_pc_hold: assert property (@(posedge clk) disable iff (rst)
        !done |=> $stable(pc_q));

    // R7: a jump never writes the stack
    a_r7_jump_no_write: assert property (@(posedge clk) disable iff (rst)
        (busy && !req_q.call) |-> !mem_we);

endmodule

// File: tb/call_seq_test.sv
module call_seq_test;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        is_call = 1'b0;
    logic [2:0]  mode = 3'd0;
    logic [15:0] opnd = 16'h0;
    logic [7:0]  idx = 8'h0;
    logic [15:0] pc_cur = 16'h0;
    logic        busy, done, mem_we;
    logic [15:0] pc_out;
    logic [7:0]  mem_addr, mem_wdata, sp_out;

    call_seq uut (
        .clk(clk), .rst(rst), .start(start), .is_call(is_call), .mode(mode),
        .opnd(opnd), .idx(idx), .pc_cur(pc_cur), .busy(busy), .done(done),
        .pc_out(pc_out), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .sp_out(sp_out)
    );

    always #(CLK_P/2) clk = ~clk;

    typedef struct {
        int kind;   // 0 = stack write, 1 = completion
        int a;
        int d;
    } item_t;

    item_t q[$];
    item_t it;
    int n_cmp = 0;
    int n_bad = 0;
    int run = 0;
    int exp_sp = 8'hFF;
    bit finished = 1'b0;

    task automatic chk(string r, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    function automatic int f_ea(int m, int op, int ix);
        case (m)
            0: return op & 8'hFF;
            1: return op & 16'hFFFF;
            2: return (op + ix) & 16'hFFFF;
            3: return (op & 8'hFF) + ix;
            default: return ix;
        endcase
    endfunction

    function automatic int f_len(int m);
        case (m)
            4: return 1;
            0, 3: return 2;
            default: return 3;
        endcase
    endfunction

    function automatic int f_cyc(bit c, int m);
        int j;
        case (m)
            0, 4: j = 2;
            1, 3: j = 3;
            default: j = 4;
        endcase
        return c ? j + 3 : j;
    endfunction

    // monitor: pops the scoreboard as writes and completions appear
    always @(negedge clk) begin
        if (!rst) begin
            if (busy) run++;
            if (mem_we) begin
                if (q.size() == 0) chk("R7 unexpected stack write", 1, 0);
                else begin
                    it = q.pop_front();
                    chk("R6 write in expected slot", 0, it.kind);
                    chk("R6 push address", mem_addr, it.a);
                    chk("R5 pushed return byte", mem_wdata, it.d);
                end
            end
            if (done) begin
                if (q.size() == 0) chk("R8 unexpected completion", 1, 0);
                else begin
                    it = q.pop_front();
                    chk("R6 completion after both pushes", 1, it.kind);
                    chk("R3 R4 busy cycle count", run, it.d);
                end
            end
            if (!busy) run = 0;
        end
    end

    task automatic do_op(bit c, int m, int op, int ix, int pc, bit poke);
        int ea, ret;
        item_t w;
        ea  = f_ea(m, op, ix);
        ret = (pc + f_len(m)) & 16'hFFFF;
        if (c) begin
            w.kind = 0; w.a = exp_sp; w.d = ret & 8'hFF; q.push_back(w);
            exp_sp = (exp_sp - 1) & 8'hFF;
            w.kind = 0; w.a = exp_sp; w.d = (ret >> 8) & 8'hFF; q.push_back(w);
            exp_sp = (exp_sp - 1) & 8'hFF;
        end
        w.kind = 1; w.a = ea; w.d = f_cyc(c, m); q.push_back(w);
        @(negedge clk);
        start = 1'b1; is_call = c; mode = 3'(m);
        opnd = 16'(op); idx = 8'(ix); pc_cur = 16'(pc);
        @(negedge clk);
        if (poke) begin
            // R8: a second request while busy must be dropped
            is_call = !c; mode = 3'd1; opnd = ~16'(op); pc_cur = 16'h1234;
            @(negedge clk);
        end
        start = 1'b0;
        while (!done) @(negedge clk);
        @(negedge clk);
        chk("R2 R10 pc loaded with target", pc_out, ea);
        chk("R6 R7 stack pointer after op", sp_out, exp_sp);
        chk("R3 idle after done", busy, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            chk("watchdog expired", 1, 0);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 mem_we", mem_we, 0);
        chk("R1 pc_out", pc_out, 0);
        chk("R1 sp_out", sp_out, 8'hFF);

        // R3 jumps in every mode
        do_op(0, 0, 16'h00A5, 8'h10, 16'h0100, 0);
        do_op(0, 1, 16'hBEEF, 8'h10, 16'h0200, 0);
        do_op(0, 2, 16'hFFF0, 8'h20, 16'h0300, 0);
        do_op(0, 3, 16'h00FF, 8'hFF, 16'h0400, 0);
        do_op(0, 4, 16'h5555, 8'h7E, 16'h0500, 0);

        // R4 R5 calls in every mode, including return address wrap
        do_op(1, 0, 16'hCC42, 8'h03, 16'h1000, 0);
        do_op(1, 1, 16'h8123, 8'h03, 16'hFFFF, 0);
        do_op(1, 2, 16'h1000, 8'h80, 16'h20FE, 0);
        do_op(1, 3, 16'h0080, 8'h90, 16'h30FF, 0);
        do_op(1, 4, 16'h0000, 8'h44, 16'h4000, 0);

        // R8 start while busy, for a short jump and a long call
        do_op(0, 0, 16'h0011, 8'h00, 16'h0600, 1);
        do_op(1, 2, 16'h0700, 8'h01, 16'h0700, 1);

        // R9 invalid mode codes
        for (int m = 5; m < 8; m++) begin
            @(negedge clk);
            start = 1'b1; is_call = 1'b1; mode = 3'(m); opnd = 16'h9999;
            @(negedge clk);
            start = 1'b0;
            chk("R9 invalid mode leaves busy low", busy, 0);
            repeat (8) @(negedge clk);
            chk("R9 pc unchanged", pc_out, f_ea(2, 16'h0700, 8'h01));
            chk("R9 sp unchanged", sp_out, exp_sp);
        end

        // R6 stack pointer wraps across zero
        for (int k = 0; k < 130; k++)
            do_op(1, k % 5, 16'h1200 + k, k & 8'hFF, 16'h8000 + 7 * k, 0);

        repeat (3) @(negedge clk);
        chk("R8 scoreboard drained", q.size(), 0);
        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule